// File: doc/BRIEF.md
# CAN Mailbox Receive Status Logic

This block sits behind a CAN receive engine. Each time a frame has been accepted from the bus, the engine gives the block one event cycle with the frame's 11-bit standard identifier, its remote flag and its length code. The block compares the identifier with the identifiers configured in sixteen mailboxes, numbered 0 to 15, and decides which mailboxes take the frame. Among mailboxes 1 to 15, exactly one takes a matching frame: the highest-numbered one that matches. Mailbox 0 takes the frame as well whenever its own identifier matches. The block reports the chosen slots and the length to use, so that the data store elsewhere can be written. For a remote frame, that length is the reply length already configured in the mailbox.

Each mailbox has three status flags. The receive-done flag shows that a frame has been stored. The remote-pending flag shows that a remote frame has been stored and is waiting for an answer. The overwrite flag shows that a frame was stored while the previous one was still unread. The CPU clears these flags with write-one-to-clear writes. A per-mailbox mask, together with two global masks, reduces the flags to a single registered, level-type interrupt line.

Top module: `can_mbx_rx_status`

## Requirements
- R1: A synchronous active-high reset clears every status flag, the interrupt line, store_valid and store_slots, and sets every mailbox identifier and configured length to zero.
- R2: A write with cfg_wr high loads cfg_ident and cfg_len into the mailbox selected by cfg_slot. A frame matches a mailbox only if all 11 identifier bits are equal.
- R3: When several of mailboxes 1 to 15 match, only the highest-numbered of them is set in store_slots and has its flags updated.
- R4: When mailbox 0 matches, it is set in store_slots in addition to any slot chosen among 1 to 15.
- R5: A data frame (rx_remote = 0) sets receive-done in every mailbox that takes it. store_len then equals rx_len.
- R6: A remote frame (rx_remote = 1) sets both receive-done and remote-pending in every mailbox that takes it. store_len then equals the configured length of the chosen mailbox among 1 to 15, or of mailbox 0 when only mailbox 0 matches.
- R7: A frame is stored even if its mailbox still has receive-done set. In that case the mailbox's overwrite flag is set as well.
- R8: With clr_wr high, each 1 bit in clr_bits clears that mailbox's flag in the group named by clr_kind: 0 receive-done, 1 remote-pending, 2 overwrite. Code 3 clears nothing.
- R9: If a flag is set by a received frame in the same cycle that the CPU clears it, the flag ends up set.
- R10: A set receive-done flag drives irq high only when its int_mask bit is 0. A mask bit of 1 disables that mailbox's interrupts.
- R11: A set remote-pending flag drives irq high only when its int_mask bit is 0 and rr_int_off is 0.
- R12: Any set overwrite flag drives irq high when ov_int_off is 0, whatever int_mask holds.
- R13: A frame that matches no mailbox leaves every flag unchanged and does not raise store_valid.
- R14: Flags, store_valid, store_slots and store_len change on the clock edge that samples rx_valid. irq follows the flags and masks one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Mailbox configuration write strobe |
| cfg_slot | input | 4 | Mailbox number to configure |
| cfg_ident | input | 11 | Identifier for the mailbox |
| cfg_len | input | 4 | Reply length code for the mailbox |
| rx_valid | input | 1 | One-cycle received-frame event |
| rx_ident | input | 11 | Identifier of the received frame |
| rx_remote | input | 1 | 1 for a remote frame |
| rx_len | input | 4 | Length code of the received frame |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_kind | input | 2 | Flag group to clear |
| clr_bits | input | 16 | Write-one-to-clear bit vector |
| int_mask | input | 16 | Per-mailbox interrupt disable |
| rr_int_off | input | 1 | Global remote-pending interrupt disable |
| ov_int_off | input | 1 | Global overwrite interrupt disable |
| store_valid | output | 1 | Frame is being stored this cycle |
| store_slots | output | 16 | Mailboxes that take the frame |
| store_len | output | 4 | Length code to store or answer with |
| rx_done | output | 16 | Receive-done flags |
| rr_pend | output | 16 | Remote-pending flags |
| ovr_flag | output | 16 | Overwrite flags |
| irq | output | 1 | Interrupt request level |

## Verification
The bench configures mailbox 0 and two higher mailboxes with the same identifier. A frame that lands in both higher mailboxes, or that skips mailbox 0, shows up as a wrong store_slots value. It sends the same frame twice in a row, so a design that refuses to store into an unread mailbox, or that does not flag the overwrite, fails. It also sends a frame whose identifier differs from a configured one only in the top bit, which shows whether the compare is partial. A clear that coincides with a new store checks that the set wins over the clear. A remote frame checks that the configured reply length is used instead of the received length. Stepping each mask one at a time shows whether an interrupt source ignores its mask or is gated by the wrong global bit.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  localparam int unsigned MBX_N = 16;
  localparam int unsigned ID_W  = 11;
  localparam int unsigned LEN_W = 4;

  typedef enum logic [1:0] {
    KIND_RXDONE = 2'd0,
    KIND_RRPEND = 2'd1,
    KIND_OVR    = 2'd2,
    KIND_NONE   = 2'd3
  } clr_kind_e;
endpackage

// File: rtl/mbx_id_table.sv
module mbx_id_table #(
  parameter int unsigned N     = 16,
  parameter int unsigned ID_W  = 11,
  parameter int unsigned LEN_W = 4,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [IDX_W-1:0]   cfg_slot,
  input  logic [ID_W-1:0]    cfg_ident,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [ID_W-1:0]    rx_ident,
  output logic [N-1:0]       hit,
  output logic [N*LEN_W-1:0] len_flat
);
  // One identifier/length register pair per mailbox, compared in parallel
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [ID_W-1:0]  id_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        id_q  <= '0;
        len_q <= '0;
      end else if (cfg_wr && (cfg_slot == IDX_W'(g))) begin
        id_q  <= cfg_ident;
        len_q <= cfg_len;
      end
    end

    assign hit[g] = (id_q == rx_ident);
    assign len_flat[g*LEN_W +: LEN_W] = len_q;
  end
endmodule

// File: rtl/mbx_select.sv
module mbx_select #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             en,
  input  logic [N-1:0]     hit,
  output logic [N-1:0]     take,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);
  // Highest-numbered hit among 1..N-1 wins; slot 0 rides along on its own hit
  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (hit[i]) begin
        pick_idx = IDX_W'(i);
        pick_any = 1'b1;
      end
    end
    take = '0;
    if (en) begin
      if (pick_any) take[pick_idx] = 1'b1;
      take[0] = hit[0];
    end
  end
endmodule

// File: rtl/mbx_flag_reg.sv
module mbx_flag_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q
);
  // Set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/mbx_irq_gate.sv
module mbx_irq_gate #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rx_done,
  input  logic [N-1:0] rr_pend,
  input  logic [N-1:0] ovr_flag,
  input  logic [N-1:0] int_mask,
  input  logic         rr_int_off,
  input  logic         ov_int_off,
  output logic         irq
);
  logic src_rx, src_rr, src_ov;

  always_comb begin
    src_rx = |(rx_done & ~int_mask);
    src_rr = !rr_int_off && (|(rr_pend & ~int_mask));
    src_ov = !ov_int_off && (|ovr_flag);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= src_rx | src_rr | src_ov;
  end
endmodule

// File: rtl/can_mbx_rx_status.sv
module can_mbx_rx_status
  import can_mbx_pkg::*;
#(
  parameter int unsigned N      = MBX_N,
  parameter int unsigned IDW    = ID_W,
  parameter int unsigned LENW   = LEN_W,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_slot,
  input  logic [IDW-1:0]   cfg_ident,
  input  logic [LENW-1:0]  cfg_len,
  input  logic             rx_valid,
  input  logic [IDW-1:0]   rx_ident,
  input  logic             rx_remote,
  input  logic [LENW-1:0]  rx_len,
  input  logic             clr_wr,
  input  logic [1:0]       clr_kind,
  input  logic [N-1:0]     clr_bits,
  input  logic [N-1:0]     int_mask,
  input  logic             rr_int_off,
  input  logic             ov_int_off,
  output logic             store_valid,
  output logic [N-1:0]     store_slots,
  output logic [LENW-1:0]  store_len,
  output logic [N-1:0]     rx_done,
  output logic [N-1:0]     rr_pend,
  output logic [N-1:0]     ovr_flag,
  output logic             irq
);
  logic [N-1:0]      hit;
  logic [N*LENW-1:0] len_flat;
  logic [N-1:0]      take;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic [LENW-1:0]   cfg_len_sel;
  logic [N-1:0]      clr_rx, clr_rr, clr_ov;
  logic [N-1:0]      set_rx, set_rr, set_ov;
  clr_kind_e         kind;

  mbx_id_table #(.N(N), .ID_W(IDW), .LEN_W(LENW)) u_table (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_slot(cfg_slot),
    .cfg_ident(cfg_ident), .cfg_len(cfg_len), .rx_ident(rx_ident),
    .hit(hit), .len_flat(len_flat)
  );

  mbx_select #(.N(N)) u_select (
    .en(rx_valid), .hit(hit), .take(take),
    .pick_idx(pick_idx), .pick_any(pick_any)
  );

  always_comb begin
    kind        = clr_kind_e'(clr_kind);
    cfg_len_sel = pick_any ? len_flat[pick_idx*LENW +: LENW] : len_flat[LENW-1:0];
    clr_rx = (clr_wr && kind == KIND_RXDONE) ? clr_bits : '0;
    clr_rr = (clr_wr && kind == KIND_RRPEND) ? clr_bits : '0;
    clr_ov = (clr_wr && kind == KIND_OVR)    ? clr_bits : '0;
    set_rx = take;
    set_rr = rx_remote ? take : '0;
    set_ov = take & rx_done;
  end

  mbx_flag_reg #(.N(N)) u_rxdone (.clk(clk), .rst(rst), .set_vec(set_rx), .clr_vec(clr_rx), .q(rx_done));
  mbx_flag_reg #(.N(N)) u_rrpend (.clk(clk), .rst(rst), .set_vec(set_rr), .clr_vec(clr_rr), .q(rr_pend));
  mbx_flag_reg #(.N(N)) u_ovr    (.clk(clk), .rst(rst), .set_vec(set_ov), .clr_vec(clr_ov), .q(ovr_flag));

  always_ff @(posedge clk) begin
    if (rst) begin
      store_valid <= 1'b0;
      store_slots <= '0;
      store_len   <= '0;
    end else begin
      store_valid <= |take;
      store_slots <= take;
      if (|take) store_len <= rx_remote ? cfg_len_sel : rx_len;
    end
  end

  mbx_irq_gate #(.N(N)) u_irq (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rr_pend(rr_pend),
    .ovr_flag(ovr_flag), .int_mask(int_mask), .rr_int_off(rr_int_off),
    .ov_int_off(ov_int_off), .irq(irq)
  );
endmodule

// File: rtl/can_mbx_rx_status_chk.sv
module can_mbx_rx_status_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_wr,
  input logic [1:0]   clr_kind,
  input logic [N-1:0] clr_bits,
  input logic         store_valid,
  input logic [N-1:0] store_slots,
  input logic [N-1:0] rx_done,
  input logic [N-1:0] rr_pend,
  input logic [N-1:0] ovr_flag,
  input logic         irq
);
  // R3
  one_upper_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(store_slots[N-1:1]) <= 1);

  // R5
  stored_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
    store_valid |-> ((rx_done & store_slots) == store_slots));

  // R7
  ovr_rise_on_store_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovr_flag & ~$past(ovr_flag) & ~store_slots) == '0));

  // R6
  rr_rise_on_store_chk: assert property (@(posedge clk) disable iff (rst)
    ((rr_pend & ~$past(rr_pend) & ~store_slots) == '0));

  // R13
  valid_matches_slots_chk: assert property (@(posedge clk) disable iff (rst)
    store_valid == (store_slots != '0));

  // R8
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_kind == 2'd0) |=> ((rx_done & $past(clr_bits) & ~store_slots) == '0));

  // R10
  no_flags_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done == '0 && rr_pend == '0 && ovr_flag == '0) |=> !irq);
endmodule

bind can_mbx_rx_status can_mbx_rx_status_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .clr_wr(clr_wr), .clr_kind(clr_kind), .clr_bits(clr_bits),
  .store_valid(store_valid), .store_slots(store_slots), .rx_done(rx_done),
  .rr_pend(rr_pend), .ovr_flag(ovr_flag), .irq(irq)
);

// File: tb/can_mbx_rx_status_tb.sv
module can_mbx_rx_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic [10:0] cfg_ident = '0;
  logic [3:0]  cfg_len = '0;
  logic        rx_valid = 1'b0;
  logic [10:0] rx_ident = '0;
  logic        rx_remote = 1'b0;
  logic [3:0]  rx_len = '0;
  logic        clr_wr = 1'b0;
  logic [1:0]  clr_kind = 2'd3;
  logic [15:0] clr_bits = '0;
  logic [15:0] int_mask = 16'hFFFF;
  logic        rr_int_off = 1'b1;
  logic        ov_int_off = 1'b1;
  logic        store_valid;
  logic [15:0] store_slots;
  logic [3:0]  store_len;
  logic [15:0] rx_done, rr_pend, ovr_flag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_mbx_rx_status dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_ident(cfg_ident),
    .cfg_len(cfg_len), .rx_valid(rx_valid), .rx_ident(rx_ident), .rx_remote(rx_remote),
    .rx_len(rx_len), .clr_wr(clr_wr), .clr_kind(clr_kind), .clr_bits(clr_bits),
    .int_mask(int_mask), .rr_int_off(rr_int_off), .ov_int_off(ov_int_off),
    .store_valid(store_valid), .store_slots(store_slots), .store_len(store_len),
    .rx_done(rx_done), .rr_pend(rr_pend), .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int slot, input logic [10:0] id, input logic [3:0] len);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_slot = 4'(slot); cfg_ident = id; cfg_len = len;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Returns at the negedge just after the edge that sampled the frame
  task automatic frame(input logic [10:0] id, input logic rem, input logic [3:0] len);
    @(negedge clk);
    rx_valid = 1'b1; rx_ident = id; rx_remote = rem; rx_len = len;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear(input logic [1:0] kind, input logic [15:0] bits);
    @(negedge clk);
    clr_wr = 1'b1; clr_kind = kind; clr_bits = bits;
    @(negedge clk);
    clr_wr = 1'b0; clr_kind = 2'd3; clr_bits = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rx_done", 32'(rx_done), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 store_valid", 32'(store_valid), 0);
  endtask

  task automatic t_config();
    for (int k = 1; k < 16; k++) cfg(k, 11'h100 + 11'(k), 4'd1);
    cfg(5, 11'h2AA, 4'd3);
    cfg(9, 11'h2AA, 4'd7);
    cfg(0, 11'h2AA, 4'd2);
    frame(11'h503, 1'b0, 4'd5);
    chk("R2 partial id no store", 32'(store_valid), 0);
    chk("R13 no flag change", 32'(rx_done), 0);
  endtask

  task automatic t_data_single();
    frame(11'h103, 1'b0, 4'd5);
    chk("R5 slots", 32'(store_slots), 32'h0008);
    chk("R5 len", 32'(store_len), 5);
    chk("R14 rx_done same edge", 32'(rx_done), 32'h0008);
    chk("R14 irq lags", 32'(irq), 0);
    settle();
    chk("R10 masked no irq", 32'(irq), 0);
    int_mask = 16'hFFF7;
    settle();
    chk("R10 unmasked irq", 32'(irq), 1);
    clear(2'd0, 16'h0008);
    chk("R8 clear rx_done", 32'(rx_done), 0);
    settle();
    chk("R8 irq drops", 32'(irq), 0);
    int_mask = 16'hFFFF;
  endtask

  task automatic t_multi_overwrite();
    frame(11'h2AA, 1'b0, 4'd6);
    chk("R3 R4 slots", 32'(store_slots), 32'h0201);
    chk("R5 done", 32'(rx_done), 32'h0201);
    frame(11'h2AA, 1'b0, 4'd4);
    chk("R7 still stored", 32'(store_slots), 32'h0201);
    chk("R7 ovr", 32'(ovr_flag), 32'h0201);
    settle();
    chk("R12 off no irq", 32'(irq), 0);
    ov_int_off = 1'b0;
    settle();
    chk("R12 on irq", 32'(irq), 1);
    clear(2'd2, 16'h0201);
    chk("R8 clear ovr", 32'(ovr_flag), 0);
    clear(2'd3, 16'hFFFF);
    chk("R8 code 3 no clear", 32'(rx_done), 32'h0201);
    clear(2'd0, 16'h0201);
    ov_int_off = 1'b1;
  endtask

  task automatic t_remote();
    frame(11'h2AA, 1'b1, 4'd0);
    chk("R6 slots", 32'(store_slots), 32'h0201);
    chk("R6 cfg len", 32'(store_len), 7);
    chk("R6 rr_pend", 32'(rr_pend), 32'h0201);
    chk("R6 rx_done", 32'(rx_done), 32'h0201);
    clear(2'd0, 16'h0201);
    int_mask = 16'hFDFF;
    settle();
    chk("R11 global off", 32'(irq), 0);
    rr_int_off = 1'b0;
    settle();
    chk("R11 enabled", 32'(irq), 1);
    int_mask = 16'hFFFF;
    settle();
    chk("R11 slot masked", 32'(irq), 0);
    clear(2'd1, 16'h0201);
    chk("R8 clear rr", 32'(rr_pend), 0);
    rr_int_off = 1'b1;
    cfg(0, 11'h055, 4'd2);
    frame(11'h055, 1'b1, 4'd0);
    chk("R6 only mb0 slots", 32'(store_slots), 32'h0001);
    chk("R6 only mb0 len", 32'(store_len), 2);
    clear(2'd0, 16'h0001);
    clear(2'd1, 16'h0001);
  endtask

  task automatic t_set_wins();
    frame(11'h104, 1'b0, 4'd2);
    @(negedge clk);
    rx_valid = 1'b1; rx_ident = 11'h104; rx_remote = 1'b0; rx_len = 4'd3;
    clr_wr = 1'b1; clr_kind = 2'd0; clr_bits = 16'h0010;
    @(negedge clk);
    rx_valid = 1'b0; clr_wr = 1'b0; clr_kind = 2'd3; clr_bits = '0;
    chk("R9 set wins", 32'(rx_done), 32'h0010);
    chk("R7 ovr on clear cycle", 32'(ovr_flag), 32'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_config();
    t_data_single();
    t_multi_overwrite();
    t_remote();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule